// File: doc/BRIEF.md
# Prioritized Level-Interrupt Controller

This block gathers a parameterized number of level-sensitive interrupt sources (96 by default, 128 in the wide variant), grouped in 32-bit banks. It selects one winner among the sources that are asserted, unmasked and urgent enough, and holds that winner until software acknowledges it. While a winner is held, a single request line to the processor stays high. The held source number can be read from a register. Software then writes an acknowledge bit, which lets the controller pick the next source.

Software works through a simple register bus. Each bank has a mask register, which is changed only through two write-one ports: one that clears mask bits and one that sets them. Each bank also has a read-only view of its masked pending sources. Each source has its own priority register. There is one global threshold and a small configuration register that holds a soft-reset trigger and an autoidle flag. A status bit reports when a reset sequence has finished. Two spare storage registers and a constant revision word complete the map.

Top module: `pic_top`

## Requirements
- R1: After reset, every mask bit reads 1, every priority register reads 0, the threshold reads 0xFF and `irq_o` is low.
- R2: Writing ones to the mask-clear port at 0x88 + 0x20*n unmasks those sources of bank n. Zero bits leave their mask bits unchanged. The mask reads back at 0x84 + 0x20*n.
- R3: Writing ones to the mask-set port at 0x8C + 0x20*n masks those sources of bank n. Zero bits leave their mask bits unchanged.
- R4: The pending word at 0x98 + 0x20*n reads as (asserted sources AND NOT mask) for bank n. It does not depend on the threshold.
- R5: The priority of source i is held in bits [7:2] of the register at 0x100 + 4*i, and 0 is the most urgent. The most urgent eligible source wins. When priorities are equal, the lowest source number wins.
- R6: A pending source is eligible only when its priority is strictly less than the threshold held in bits [7:0] at 0x68. A threshold of 0xFF lets every priority through.
- R7: One clock edge after a source becomes eligible with nothing held, its number is latched. The number reads from bits [6:0] at 0x40, and `irq_o` goes high. While a number is held, it stays frozen even if a more urgent source appears.
- R8: Writing 1 to bit 0 at 0x48 releases the held source, and `irq_o` is low after that edge. The next winner is latched on the following edge. A write to 0x48 with bit 0 equal to 0 has no effect.
- R9: Writing 1 to bit 1 at 0x10 starts a soft reset. Bit 0 at 0x14 reads 0 until RST_CYC edges later, then reads 1. The soft reset returns masks, priorities, threshold, the held source and the config register to their reset values. Bit 1 always reads back 0. Bit 0 at 0x10 stores the autoidle flag.
- R10: The word at 0x00 returns the major revision in bits [7:4] and the minor revision in bits [3:0].
- R11: The registers at 0x4C and 0x50 store and return bits [7:0] of what is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Level-sensitive interrupt sources |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered; valid after the edge that samples `rd_en` |
| irq_o | output | 1 | Interrupt request, high while a source is held |

## Verification
Register writes take effect at the edge that samples `wr_en`. Read data appears right after the edge that samples `rd_en`, so every read result is due one edge after it is issued. A change in sources or masks shows on `irq_o` and on the active-source register one edge after that change. After an acknowledge, `irq_o` is low immediately after the write edge, and the next winner appears one edge later. A soft reset completes RST_CYC edges after the write. The bench queues each expected read value when the read is driven. It compares the value a fixed offset after the sampling edge, and it checks `irq_o` exactly in the cycle just after the edge that is due to change it.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int BANK_W = 32;
    localparam int PRIO_W = 6;
    localparam int ID_W   = 7;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;

    localparam logic [ADDR_W-1:0] OFF_REV   = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_CFG   = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_ACT   = 12'h040;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h048;
    localparam logic [ADDR_W-1:0] OFF_PROT  = 12'h04C;
    localparam logic [ADDR_W-1:0] OFF_IDLE  = 12'h050;
    localparam logic [ADDR_W-1:0] OFF_THR   = 12'h068;
    localparam logic [ADDR_W-1:0] OFF_BANK0 = 12'h080;
    localparam logic [ADDR_W-1:0] OFF_LVL0  = 12'h100;
    localparam int BANK_STRIDE = 32;

    typedef enum logic [2:0] {
        BP_NONE,
        BP_MASK,
        BP_CLR,
        BP_SET,
        BP_PEND
    } bank_port_e;

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
    } pick_t;

    function automatic bank_port_e bank_port(input logic [4:0] sub);
        case (sub)
            5'h04:   return BP_MASK;
            5'h08:   return BP_CLR;
            5'h0C:   return BP_SET;
            5'h18:   return BP_PEND;
            default: return BP_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] prio_word(input logic [PRIO_W-1:0] p);
        return {{(DATA_W-PRIO_W-2){1'b0}}, p, 2'b00};
    endfunction

endpackage

// File: rtl/pic_mask_bank.sv
module pic_mask_bank
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              unmask_we,
    input  logic              mask_we,
    input  logic [BANK_W-1:0] bits,
    input  logic [BANK_W-1:0] src,
    output logic [BANK_W-1:0] mask_q,
    output logic [BANK_W-1:0] pend
);

    always_ff @(posedge clk) begin
        if (clr) begin
            mask_q <= '1;
        end else if (unmask_we) begin
            mask_q <= mask_q & ~bits;
        end else if (mask_we) begin
            mask_q <= mask_q | bits;
        end
    end

    assign pend = src & ~mask_q;

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int N_SRC = 96
) (
    input  logic [N_SRC-1:0]             elig,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
    output pick_t                        win
);

    always_comb begin
        logic [PRIO_W-1:0] best;
        best = '1;
        win  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && (!win.valid || prio[i] < best)) begin
                best      = prio[i];
                win.valid = 1'b1;
                win.id    = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/pic_soft_reset.sv
module pic_soft_reset #(
    parameter int RST_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(RST_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt  <= CW'(RST_CYC);
            done <= 1'b0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
                done <= 1'b1;
            end
        end
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
#(
    parameter int N_SRC   = 96,
    parameter int RST_CYC = 4,
    parameter int REV_MAJ = 2,
    parameter int REV_MIN = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [11:0]       addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq_o
);

    localparam int NBANK = N_SRC / BANK_W;

    logic                        busy;
    logic                        rst_done;
    logic                        clr;
    logic                        soft_start;
    logic                        ack_we;
    logic                        autoidle_q;
    logic [BYTE_W-1:0]           thr_q;
    logic [BYTE_W-1:0]           prot_q;
    logic [BYTE_W-1:0]           idle_q;
    logic [N_SRC-1:0][PRIO_W-1:0] lvl_q;
    logic [N_SRC-1:0]            lvl_hit;
    logic [N_SRC-1:0]            pend_all;
    logic [N_SRC-1:0]            elig;
    logic [NBANK-1:0]            bank_hit;
    logic [NBANK-1:0][BANK_W-1:0] mask_q;
    logic [NBANK-1:0][BANK_W-1:0] pend_q;
    bank_port_e                  port;
    pick_t                       win;
    pick_t                       held_q;
    logic [DATA_W-1:0]           rd_word;
    logic                        held_valid;
    logic [ID_W-1:0]             held_id;
    logic                        win_valid;
    logic [ID_W-1:0]             win_id;

    assign clr        = rst | busy;
    assign soft_start = wr_en && !busy && (addr == OFF_CFG) && wdata[1];
    assign ack_we     = wr_en && !busy && (addr == OFF_CTRL) && wdata[0];
    assign port       = bank_port(addr[4:0]);

    pic_soft_reset #(.RST_CYC(RST_CYC)) u_soft_reset (
        .clk   (clk),
        .rst   (rst),
        .start (soft_start),
        .busy  (busy),
        .done  (rst_done)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] BASE = OFF_BANK0 + ADDR_W'(b * BANK_STRIDE);
        logic unmask_we;
        logic mask_we;
        assign bank_hit[b] = (addr[ADDR_W-1:5] == BASE[ADDR_W-1:5]);
        assign unmask_we   = wr_en && !busy && bank_hit[b] && (port == BP_CLR);
        assign mask_we     = wr_en && !busy && bank_hit[b] && (port == BP_SET);

        pic_mask_bank u_bank (
            .clk       (clk),
            .clr       (clr),
            .unmask_we (unmask_we),
            .mask_we   (mask_we),
            .bits      (wdata),
            .src       (src_i[b*BANK_W +: BANK_W]),
            .mask_q    (mask_q[b]),
            .pend      (pend_q[b])
        );
        assign pend_all[b*BANK_W +: BANK_W] = pend_q[b];
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign lvl_hit[i] = (addr == OFF_LVL0 + ADDR_W'(4 * i));
        assign elig[i]    = pend_all[i] && ({2'b00, lvl_q[i]} < thr_q);
    end

    pic_arbiter #(.N_SRC(N_SRC)) u_arbiter (
        .elig (elig),
        .prio (lvl_q),
        .win  (win)
    );

    always_ff @(posedge clk) begin
        if (clr) begin
            thr_q      <= '1;
            prot_q     <= '0;
            idle_q     <= '0;
            autoidle_q <= 1'b0;
            lvl_q      <= '0;
        end else if (wr_en) begin
            if (addr == OFF_THR)  thr_q      <= wdata[BYTE_W-1:0];
            if (addr == OFF_PROT) prot_q     <= wdata[BYTE_W-1:0];
            if (addr == OFF_IDLE) idle_q     <= wdata[BYTE_W-1:0];
            if (addr == OFF_CFG)  autoidle_q <= wdata[0];
            for (int i = 0; i < N_SRC; i++) begin
                if (lvl_hit[i]) lvl_q[i] <= wdata[PRIO_W+1:2];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            held_q <= '0;
        end else if (ack_we) begin
            held_q <= '0;
        end else if (!held_q.valid && win.valid) begin
            held_q <= win;
        end
    end

    assign held_valid = held_q.valid;
    assign held_id    = held_q.id;
    assign win_valid  = win.valid;
    assign win_id     = win.id;
    assign irq_o      = held_valid;

    always_comb begin
        rd_word = '0;
        case (addr)
            OFF_REV:  rd_word = {{(DATA_W-BYTE_W){1'b0}}, 4'(REV_MAJ), 4'(REV_MIN)};
            OFF_CFG:  rd_word = {{(DATA_W-1){1'b0}}, autoidle_q};
            OFF_STAT: rd_word = {{(DATA_W-1){1'b0}}, rst_done};
            OFF_ACT:  rd_word = {{(DATA_W-ID_W){1'b0}}, held_id};
            OFF_PROT: rd_word = {{(DATA_W-BYTE_W){1'b0}}, prot_q};
            OFF_IDLE: rd_word = {{(DATA_W-BYTE_W){1'b0}}, idle_q};
            OFF_THR:  rd_word = {{(DATA_W-BYTE_W){1'b0}}, thr_q};
            default:  rd_word = '0;
        endcase
        for (int b = 0; b < NBANK; b++) begin
            if (bank_hit[b] && port == BP_MASK) rd_word = mask_q[b];
            if (bank_hit[b] && port == BP_PEND) rd_word = pend_q[b];
        end
        for (int i = 0; i < N_SRC; i++) begin
            if (lvl_hit[i]) rd_word = prio_word(lvl_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_word;
        end
    end

endmodule

// File: rtl/pic_checker.sv
module pic_checker
    import pic_pkg::*;
#(
    parameter int N_SRC = 96
) (
    input logic             clk,
    input logic             rst,
    input logic             irq_o,
    input logic             held_valid,
    input logic [ID_W-1:0]  held_id,
    input logic             win_valid,
    input logic [ID_W-1:0]  win_id,
    input logic [N_SRC-1:0] elig,
    input logic             ack_we,
    input logic             soft_start,
    input logic             busy,
    input logic             rst_done
);

    // R7: a held number is frozen until acknowledge or reset
    a_r7_held_frozen: assert property (@(posedge clk) disable iff (rst)
        held_valid && !ack_we && !busy |=> held_valid && $stable(held_id));

    // R7: the request only rises after the arbiter offered a winner
    a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(win_valid));

    // R8: acknowledge drops the request on the next edge
    a_r8_ack_drops: assert property (@(posedge clk) disable iff (rst)
        ack_we && !busy |=> !irq_o);

    // R5 / R6: the arbiter only offers an eligible source
    a_r5_win_eligible: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> elig[int'(win_id)]);

    // R9: starting a soft reset withdraws the done bit
    a_r9_start_clears_done: assert property (@(posedge clk) disable iff (rst)
        soft_start |=> !rst_done);

    // R9: no request survives a reset sequence in progress
    a_r9_busy_quiet: assert property (@(posedge clk) disable iff (rst)
        busy |=> !irq_o);

endmodule

bind pic_top pic_checker #(.N_SRC(N_SRC)) u_pic_checker (
    .clk        (clk),
    .rst        (rst),
    .irq_o      (irq_o),
    .held_valid (held_valid),
    .held_id    (held_id),
    .win_valid  (win_valid),
    .win_id     (win_id),
    .elig       (elig),
    .ack_we     (ack_we),
    .soft_start (soft_start),
    .busy       (busy),
    .rst_done   (rst_done)
);

// File: tb/pic_top_test.sv
`timescale 1ns/1ps
module pic_top_test;

    localparam int N_SRC = 96;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_SRC-1:0]  src_i = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [11:0]       addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              irq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] exp;
        logic [11:0] a;
        string       req;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    pic_top #(.N_SRC(N_SRC)) uut (
        .clk   (clk),
        .rst   (rst),
        .src_i (src_i),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq_o (irq_o)
    );

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd_exp(input logic [11:0] a, input logic [31:0] e, input string req);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back('{exp: e, a: a, req: req});
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string req);
        checks++;
        if (irq_o !== e) begin
            errors++;
            $display("FAIL %s irq_o actual=%b expected=%b at %0t", req, irq_o, e, $time);
        end
    endtask

    task automatic set_src(input int idx, input logic v);
        @(negedge clk);
        src_i[idx] = v;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // monitor: compare each read result one edge after it was issued
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                #2;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard empty actual=%h expected=none", rdata);
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    if (rdata !== it.exp) begin
                        errors++;
                        $display("FAIL %s addr=%h actual=%h expected=%h", it.req, it.a, rdata, it.exp);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (8) step();

        // R1 reset state
        chk_irq(1'b0, "R1");
        rd_exp(12'h014, 32'h1, "R1 done");
        rd_exp(12'h084, 32'hFFFF_FFFF, "R1 mask0");
        rd_exp(12'h0C4, 32'hFFFF_FFFF, "R1 mask2");
        rd_exp(12'h068, 32'hFF, "R1 thr");
        rd_exp(12'h114, 32'h0, "R1 prio5");
        // R10 revision
        rd_exp(12'h000, 32'h21, "R10");
        // R11 spare registers
        wr(12'h04C, 32'hABCD_0001);
        wr(12'h050, 32'h0000_0103);
        rd_exp(12'h04C, 32'h01, "R11 prot");
        rd_exp(12'h050, 32'h03, "R11 idle");

        // R5 priorities
        wr(12'h100 + 12'(4*3),  32'h14);
        wr(12'h100 + 12'(4*7),  32'h08);
        wr(12'h100 + 12'(4*40), 32'h08);
        wr(12'h100 + 12'(4*70), 32'h24);
        rd_exp(12'h100 + 12'(4*70), 32'h24, "R5 readback");

        // R2 unmask ports
        wr(12'h088, 32'h0000_0088);
        wr(12'h088, 32'h0);
        wr(12'h0A8, 32'h0000_0100);
        wr(12'h0C8, 32'h0000_0040);
        rd_exp(12'h084, 32'hFFFF_FF77, "R2 mask0");
        rd_exp(12'h0A4, 32'hFFFF_FEFF, "R2 mask1");

        // R7 latch one edge after source
        set_src(3, 1'b1);
        step();
        chk_irq(1'b1, "R7 latch");
        rd_exp(12'h040, 32'd3, "R7 active");
        rd_exp(12'h098, 32'h8, "R4 pend0");
        // R7 frozen while better source appears
        set_src(7, 1'b1);
        step();
        rd_exp(12'h040, 32'd3, "R7 frozen");
        rd_exp(12'h098, 32'h88, "R4 pend0 two");

        // R8 acknowledge
        wr(12'h048, 32'h1);
        chk_irq(1'b0, "R8 drop");
        step();
        chk_irq(1'b1, "R8 relatch");
        rd_exp(12'h040, 32'd7, "R5 urgent wins");

        // R5 tie goes to lowest number
        set_src(40, 1'b1);
        wr(12'h048, 32'h1);
        step();
        rd_exp(12'h040, 32'd7, "R5 tie low");
        set_src(7, 1'b0);
        wr(12'h048, 32'h1);
        step();
        rd_exp(12'h040, 32'd40, "R5 tie next");
        // R8 bit0 clear has no effect
        wr(12'h048, 32'h2);
        step();
        chk_irq(1'b1, "R8 no effect");
        rd_exp(12'h040, 32'd40, "R8 no effect");

        // R6 threshold
        wr(12'h068, 32'h02);
        wr(12'h048, 32'h1);
        step();
        step();
        chk_irq(1'b0, "R6 filtered");
        rd_exp(12'h098, 32'h8, "R4 pend ignores thr");
        wr(12'h068, 32'h03);
        step();
        chk_irq(1'b1, "R6 pass");
        rd_exp(12'h040, 32'd40, "R6 pass id");

        // R6 0xFF passes all, R5 order between prio 5 and 9
        set_src(40, 1'b0);
        set_src(70, 1'b1);
        wr(12'h068, 32'hFF);
        wr(12'h048, 32'h1);
        step();
        rd_exp(12'h040, 32'd3, "R6 open");
        // R3 mask via set port
        wr(12'h08C, 32'h0000_0008);
        wr(12'h08C, 32'h0);
        rd_exp(12'h084, 32'hFFFF_FF7F, "R3 mask0");
        rd_exp(12'h098, 32'h0, "R3 pend0");
        wr(12'h048, 32'h1);
        step();
        rd_exp(12'h040, 32'd70, "R2 bank2 source");
        rd_exp(12'h0D8, 32'h40, "R4 pend2");

        // R9 soft reset
        wr(12'h010, 32'h3);
        rd_exp(12'h014, 32'h0, "R9 busy");
        repeat (8) step();
        rd_exp(12'h014, 32'h1, "R9 done");
        chk_irq(1'b0, "R9 irq cleared");
        rd_exp(12'h010, 32'h0, "R9 cfg reset");
        rd_exp(12'h0C4, 32'hFFFF_FFFF, "R9 mask2");
        rd_exp(12'h100 + 12'(4*70), 32'h0, "R9 prio");
        rd_exp(12'h040, 32'h0, "R9 active");
        wr(12'h010, 32'h1);
        rd_exp(12'h010, 32'h1, "R9 autoidle");
        rd_exp(12'h014, 32'h1, "R9 no restart");

        repeat (3) step();
        if (exp_q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard left=%0d expected=0", exp_q.size());
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule